// File: doc/BRIEF.md
# Four-Port Message Switch with Manager Steering

This block is one switching element of an on-chip message network. Each of its four ports carries messages made of a 2-bit class, a 16-bit destination address and a 32-bit payload. The class 00 marks an idle cycle. The switch compares each arriving destination against a small table that holds one inclusive address window per output port. The window table is filled in from the address ranges that the attached nodes receive at power-up. The switch then forwards the message on the port whose window matches.

One port is recorded as the path toward the network manager. Management responses travel on that port whatever address they carry. A message that no window claims is redirected there instead of being lost, and so is a message whose only match would send it back out of the port it came from. When two inputs want the same output in one cycle, a per-output round-robin arbiter picks one. The other input sees its ready signal low and keeps presenting its message.

A configuration write port sets the windows, the manager port and the switch identifier. These writes go into a staging copy. The live copy takes them over only on a clock edge at which every input is idle, so a message that is waiting for an output never changes its route.

Top module: `msg_switch`

## Requirements
- R1: An input whose class is 00 is idle. It is never forwarded, and its ready signal is high.
- R2: An accepted message appears on its output one clock edge after it is accepted, with class, address and payload unchanged. An output carries class 00 and zero fields in every cycle in which it forwards nothing.
- R3: A message that is not a management response goes to the output port whose window contains its destination. A window runs from its base to its limit, and both ends are included.
- R4: When several windows contain the destination, the port with the lowest index is chosen.
- R5: When several inputs target one output in the same cycle, exactly one of them is granted. Grants rotate round-robin, starting from the input after the last winner of that output. A losing input has ready low, keeps its message, and is forwarded unchanged in a later cycle.
- R6: A message is stray when no window contains its destination, or when the only chosen window belongs to its own arrival port. A stray message goes to the manager port.
- R7: A message is a management response when its class is 11 and payload bit 31 is 1. Such a message goes to the manager port whatever its destination. A class 11 message with payload bit 31 equal to 0 is routed by address like any other message.
- R8: No message ever leaves on the port it arrived on. If the manager redirect would pick the arrival port, the message is accepted (ready high) and discarded.
- R9: Configuration writes are staged. The live settings take them over on the first clock edge at which all four inputs are idle. A message that is presented while a write is pending keeps the route it had under the old settings.
- R10: The configuration selector picks the field to write: 0 sets a window base, 1 sets a window limit (the port index picks the window), 2 sets the manager port and 3 sets the switch identifier. After reset every window is empty (base FFFF, limit 0000), the manager port is 0 and the identifier is 0.
- R11: The identifier output shows the committed switch identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_cls | input | 8 | Message class per input port, 2 bits each, port 0 in the low bits |
| in_addr | input | 64 | Destination address per input port, 16 bits each |
| in_data | input | 128 | Payload per input port, 32 bits each |
| in_ready | output | 4 | High when the message on that input is accepted this cycle |
| out_cls | output | 8 | Message class per output port, 00 when idle |
| out_addr | output | 64 | Destination address per output port |
| out_data | output | 128 | Payload per output port |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field selector: 0 base, 1 limit, 2 manager port, 3 identifier |
| cfg_idx | input | 2 | Window index for base and limit writes |
| cfg_data | input | 16 | Value to write |
| sw_id | output | 8 | Committed switch identifier |

## Verification
The ready signals are combinational, so the bench reads them in the same cycle as the stimulus, a few nanoseconds before the rising edge. Forwarded messages come out of one register stage, so each output is sampled one nanosecond after the edge that accepted the message. A configuration change needs one edge to reach the staging copy and one more edge with all inputs idle to go live. The bench therefore sends a probe message only after both edges. In the frozen-route test it checks the held message on the edge that follows the write.

// File: rtl/msw_pkg.sv
// Package: shared encodings for the message switch.
// Assumes: 2-bit class field on every port; 2-bit configuration selector.
package msw_pkg;

    typedef enum logic [1:0] {
        CLS_IDLE  = 2'b00,
        CLS_READ  = 2'b01,
        CLS_WRITE = 2'b10,
        CLS_MGMT  = 2'b11
    } msg_cls_e;

    typedef enum logic [1:0] {
        CFG_BASE  = 2'd0,
        CFG_LIMIT = 2'd1,
        CFG_MGR   = 2'd2,
        CFG_ID    = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/msw_cfg.sv
// Module: staged configuration store for the switch.
// Holds a staging copy and a live copy of the port windows, the manager
// port and the switch identifier. Writes land in the staging copy; the
// live copy takes it over on an edge where the switch is not busy.
// Assumes: IDW <= AW and PW <= AW; manager port values written are < NP.
module msw_cfg
    import msw_pkg::*;
#(
    parameter int NP  = 4,
    parameter int AW  = 16,
    parameter int IDW = 8,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [1:0]             cfg_sel,
    input  logic [PW-1:0]          cfg_idx,
    input  logic [AW-1:0]          cfg_data,
    input  logic                   busy,
    output logic [NP-1:0][AW-1:0]  base_o,
    output logic [NP-1:0][AW-1:0]  limit_o,
    output logic [PW-1:0]          mgr_o,
    output logic [IDW-1:0]         id_o
);

    logic [NP-1:0][AW-1:0] stg_base, stg_limit;
    logic [PW-1:0]         stg_mgr;
    logic [IDW-1:0]        stg_id;

    // Purpose: capture configuration writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_base  <= {NP{{AW{1'b1}}}};
            stg_limit <= '0;
            stg_mgr   <= '0;
            stg_id    <= '0;
        end else if (cfg_wr) begin
            case (cfg_sel)
                CFG_BASE:  stg_base[cfg_idx]  <= cfg_data;
                CFG_LIMIT: stg_limit[cfg_idx] <= cfg_data;
                CFG_MGR:   stg_mgr            <= cfg_data[PW-1:0];
                default:   stg_id             <= cfg_data[IDW-1:0];
            endcase
        end
    end

    // Purpose: commit the staging copy only between messages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= {NP{{AW{1'b1}}}};
            limit_o <= '0;
            mgr_o   <= '0;
            id_o    <= '0;
        end else if (!busy) begin
            base_o  <= stg_base;
            limit_o <= stg_limit;
            mgr_o   <= stg_mgr;
            id_o    <= stg_id;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_o) && $stable(limit_o) && $stable(mgr_o) && $stable(id_o))); // R9

endmodule

// File: rtl/msw_route.sv
// Module: destination lookup for one input port.
// Compares the destination with every port window, picks the lowest
// matching index, and redirects management responses and stray messages
// to the manager port. Flags a drop when the result is the arrival port.
// Assumes: windows are inclusive at both ends; SELF is this input's index.
module msw_route
    import msw_pkg::*;
#(
    parameter int NP   = 4,
    parameter int AW   = 16,
    parameter int SELF = 0,
    localparam int PW  = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [1:0]             cls,
    input  logic [AW-1:0]          addr,
    input  logic                   resp_flag,
    input  logic [NP-1:0][AW-1:0]  base,
    input  logic [NP-1:0][AW-1:0]  limit,
    input  logic [PW-1:0]          mgr,
    output logic                   req_o,
    output logic                   drop_o,
    output logic [PW-1:0]          tgt_o
);

    localparam logic [PW-1:0] SELF_IDX = PW'(SELF);

    logic [NP-1:0] hit;
    logic          found;
    logic [PW-1:0] hit_idx;
    logic          active;
    logic          is_resp;
    logic [PW-1:0] cand;

    // Purpose: compare the destination against every window.
    always_comb begin
        for (int j = 0; j < NP; j++) begin
            hit[j] = (addr >= base[j]) && (addr <= limit[j]);
        end
    end

    // Purpose: lowest matching window wins.
    always_comb begin
        found   = 1'b0;
        hit_idx = '0;
        for (int j = NP - 1; j >= 0; j--) begin
            if (hit[j]) begin
                found   = 1'b1;
                hit_idx = PW'(j);
            end
        end
    end

    // Purpose: choose the output, steering responses and strays to the manager.
    always_comb begin
        active  = (cls != CLS_IDLE);
        is_resp = (cls == CLS_MGMT) && resp_flag;
        if (is_resp)
            cand = mgr;
        else if (found && (hit_idx != SELF_IDX))
            cand = hit_idx;
        else
            cand = mgr;
        tgt_o  = cand;
        drop_o = active && (cand == SELF_IDX);
        req_o  = active && (cand != SELF_IDX);
    end

endmodule

// File: rtl/msw_arb.sv
// Module: round-robin arbiter for one output port.
// Grants one requesting input per cycle, searching from the input after
// the previous winner. The pointer moves only when a grant is issued.
// Assumes: requests are held by the inputs until granted.
module msw_arb #(
    parameter int NP  = 4,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    output logic [NP-1:0] gnt
);

    logic [PW-1:0] ptr;
    logic [PW-1:0] win;
    logic          any;

    // Purpose: find the first requester at or after the pointer.
    always_comb begin
        gnt = '0;
        win = '0;
        any = 1'b0;
        for (int k = 0; k < NP; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= NP) c = c - NP;
            if (!any && req[c]) begin
                any    = 1'b1;
                gnt[c] = 1'b1;
                win    = PW'(c);
            end
        end
    end

    // Purpose: advance the pointer past the last winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (any)
            ptr <= (win == PW'(NP - 1)) ? '0 : win + 1'b1;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R5
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R5

endmodule

// File: rtl/msg_switch.sv
// Module: four-port message switch, top level.
// Each input gets a route lookup; each output gets a round-robin arbiter
// and a register stage. Inputs that lose arbitration see in_ready low and
// must hold their message. Configuration goes through a staged store.
// Assumes: outputs are never back-pressured by the next hop.
module msg_switch
    import msw_pkg::*;
#(
    parameter int NP  = 4,
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int IDW = 8,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP*2-1:0]  in_cls,
    input  logic [NP*AW-1:0] in_addr,
    input  logic [NP*DW-1:0] in_data,
    output logic [NP-1:0]    in_ready,
    output logic [NP*2-1:0]  out_cls,
    output logic [NP*AW-1:0] out_addr,
    output logic [NP*DW-1:0] out_data,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [PW-1:0]    cfg_idx,
    input  logic [AW-1:0]    cfg_data,
    output logic [IDW-1:0]   sw_id
);

    logic [NP-1:0][1:0]    cls_a;
    logic [NP-1:0][AW-1:0] addr_a;
    logic [NP-1:0][DW-1:0] data_a;

    logic [NP-1:0][1:0]    ocls_q;
    logic [NP-1:0][AW-1:0] oaddr_q;
    logic [NP-1:0][DW-1:0] odata_q;

    logic [NP-1:0][AW-1:0] win_base, win_limit;
    logic [PW-1:0]         mgr_port;

    logic [NP-1:0]          rt_req, rt_drop;
    logic [NP-1:0][PW-1:0]  rt_tgt;
    logic [NP-1:0][NP-1:0]  req_m;   // [output][input]
    logic [NP-1:0][NP-1:0]  gnt_m;   // [output][input]
    logic                   busy;

    assign cls_a    = in_cls;
    assign addr_a   = in_addr;
    assign data_a   = in_data;
    assign out_cls  = ocls_q;
    assign out_addr = oaddr_q;
    assign out_data = odata_q;

    // Purpose: the switch is busy while any input presents a message.
    always_comb begin
        busy = 1'b0;
        for (int i = 0; i < NP; i++) busy |= (cls_a[i] != CLS_IDLE);
    end

    msw_cfg #(.NP(NP), .AW(AW), .IDW(IDW)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_idx  (cfg_idx),
        .cfg_data (cfg_data),
        .busy     (busy),
        .base_o   (win_base),
        .limit_o  (win_limit),
        .mgr_o    (mgr_port),
        .id_o     (sw_id)
    );

    for (genvar i = 0; i < NP; i++) begin : g_in
        msw_route #(.NP(NP), .AW(AW), .SELF(i)) route_i (
            .cls       (cls_a[i]),
            .addr      (addr_a[i]),
            .resp_flag (data_a[i][DW-1]),
            .base      (win_base),
            .limit     (win_limit),
            .mgr       (mgr_port),
            .req_o     (rt_req[i]),
            .drop_o    (rt_drop[i]),
            .tgt_o     (rt_tgt[i])
        );
    end

    // Purpose: spread each input's request onto its target output.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req_m[o][i] = rt_req[i] && (rt_tgt[i] == PW'(o));
            end
        end
    end

    // Purpose: accept idle, dropped and granted inputs; hold the rest.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            logic granted;
            granted = 1'b0;
            for (int o = 0; o < NP; o++) granted |= gnt_m[o][i];
            in_ready[i] = (cls_a[i] == CLS_IDLE) || rt_drop[i] || granted;
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        logic [PW-1:0] src;
        logic          sel_any;

        msw_arb #(.NP(NP)) arb_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_m[o]),
            .gnt   (gnt_m[o])
        );

        // Purpose: turn the one-hot grant into a source index.
        always_comb begin
            src     = '0;
            sel_any = 1'b0;
            for (int i = 0; i < NP; i++) begin
                if (gnt_m[o][i]) begin
                    src     = PW'(i);
                    sel_any = 1'b1;
                end
            end
        end

        // Purpose: register the granted message onto this output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ocls_q[o]  <= CLS_IDLE;
                oaddr_q[o] <= '0;
                odata_q[o] <= '0;
            end else if (sel_any) begin
                ocls_q[o]  <= cls_a[src];
                oaddr_q[o] <= addr_a[src];
                odata_q[o] <= data_a[src];
            end else begin
                ocls_q[o]  <= CLS_IDLE;
                oaddr_q[o] <= '0;
                odata_q[o] <= '0;
            end
        end

        AST_IDLE_NOT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
            (ocls_q[o] != CLS_IDLE) |-> $past(busy)); // R1
        AST_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
            !gnt_m[o][o]); // R8
        AST_RESP_TO_MGR: assert property (@(posedge clk) disable iff (!rst_n)
            ((ocls_q[o] == CLS_MGMT) && odata_q[o][DW-1]) |-> (PW'(o) == $past(mgr_port))); // R7
    end

endmodule

// File: tb/msg_switch_tb.sv
module msg_switch_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   in_cls = '0;
    logic [63:0]  in_addr = '0;
    logic [127:0] in_data = '0;
    logic [3:0]   in_ready;
    logic [7:0]   out_cls;
    logic [63:0]  out_addr;
    logic [127:0] out_data;
    logic         cfg_wr = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [1:0]   cfg_idx = '0;
    logic [15:0]  cfg_data = '0;
    logic [7:0]   sw_id;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    msg_switch dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_cls(in_cls), .in_addr(in_addr), .in_data(in_data), .in_ready(in_ready),
        .out_cls(out_cls), .out_addr(out_addr), .out_data(out_data),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .sw_id(sw_id)
    );

    // Vector: src(2) cls(2) addr(16) data(32) expected output (3, 4 = none)
    localparam logic [54:0] VEC [0:11] = '{
        {2'd0, 2'b10, 16'h1234, 32'h0000_0001, 3'd1},
        {2'd1, 2'b01, 16'h2100, 32'h0000_0002, 3'd2},
        {2'd2, 2'b10, 16'h3001, 32'h0000_0003, 3'd3},
        {2'd3, 2'b10, 16'h0005, 32'h0000_0004, 3'd0},
        {2'd0, 2'b10, 16'h1900, 32'h0000_0005, 3'd1},
        {2'd0, 2'b10, 16'h0100, 32'h0000_0006, 3'd3},
        {2'd1, 2'b10, 16'h8000, 32'h0000_0007, 3'd3},
        {2'd0, 2'b11, 16'h1234, 32'h8000_0008, 3'd3},
        {2'd0, 2'b11, 16'h2000, 32'h0000_0009, 3'd2},
        {2'd3, 2'b11, 16'h0005, 32'h8000_000A, 3'd4},
        {2'd3, 2'b10, 16'h3100, 32'h0000_000B, 3'd4},
        {2'd2, 2'b00, 16'h1000, 32'h0000_000C, 3'd4}
    };
    localparam string VTAG [0:11] = '{"R3", "R3", "R3", "R3", "R4", "R6",
                                      "R6", "R7", "R7", "R8", "R8", "R1"};

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic idle_all();
        in_cls  = '0;
        in_addr = '0;
        in_data = '0;
    endtask

    task automatic put(input int p, input logic [1:0] c, input logic [15:0] a, input logic [31:0] d);
        in_cls[2*p +: 2]   = c;
        in_addr[16*p +: 16] = a;
        in_data[32*p +: 32] = d;
    endtask

    // Writes one field, then leaves an idle edge so the write goes live.
    task automatic cfg_put(input logic [1:0] s, input logic [1:0] ix, input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_idx = ix; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [63:0] port_msg(input int p);
        return {14'd0, out_cls[2*p +: 2], out_addr[16*p +: 16], out_data[32*p +: 32]};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 / R2 / R1: reset state
        #1;
        chk("R2", {56'd0, out_cls}, 64'd0);
        chk("R1", {60'd0, in_ready}, 64'hF);
        chk("R10", {56'd0, sw_id}, 64'd0);

        // R10: empty windows after reset, manager port 0 -> stray goes to port 0
        @(negedge clk);
        put(1, 2'b10, 16'h1234, 32'h0000_00AA);
        @(posedge clk); #1;
        chk("R10", port_msg(0), {14'd0, 2'b10, 16'h1234, 32'h0000_00AA});
        chk("R10", {56'd0, out_cls[7:2]}, 64'd0);
        @(negedge clk); idle_all();

        // Program windows, manager port and identifier
        cfg_put(2'd0, 2'd0, 16'h0000); cfg_put(2'd1, 2'd0, 16'h0FFF);
        cfg_put(2'd0, 2'd1, 16'h1000); cfg_put(2'd1, 2'd1, 16'h1FFF);
        cfg_put(2'd0, 2'd2, 16'h1800); cfg_put(2'd1, 2'd2, 16'h2FFF);
        cfg_put(2'd0, 2'd3, 16'h3000); cfg_put(2'd1, 2'd3, 16'h3FFF);
        cfg_put(2'd2, 2'd0, 16'h0003);
        cfg_put(2'd3, 2'd0, 16'h005C);
        chk("R11", {56'd0, sw_id}, 64'h5C);

        // R5: contention on output 2, pointer starts at input 0
        put(0, 2'b10, 16'h2100, 32'h0000_0D01);
        put(1, 2'b10, 16'h2100, 32'h0000_0D02);
        #4;
        chk("R5", {62'd0, in_ready[1:0]}, 64'b01);
        @(posedge clk); #1;
        chk("R5", port_msg(2), {14'd0, 2'b10, 16'h2100, 32'h0000_0D01});
        @(negedge clk);
        put(0, 2'b10, 16'h2100, 32'h0000_0D03);
        #4;
        chk("R5", {62'd0, in_ready[1:0]}, 64'b10);
        @(posedge clk); #1;
        chk("R5", port_msg(2), {14'd0, 2'b10, 16'h2100, 32'h0000_0D02});
        @(negedge clk);
        put(1, 2'b00, 16'h0000, 32'h0);
        @(posedge clk); #1;
        chk("R5", port_msg(2), {14'd0, 2'b10, 16'h2100, 32'h0000_0D03});
        @(negedge clk); idle_all();

        // R9: a write while a message is held must not change its route
        @(negedge clk);
        put(0, 2'b10, 16'h2100, 32'h0000_0E01);
        put(1, 2'b10, 16'h2100, 32'h0000_0E02);
        cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_idx = 2'd2; cfg_data = 16'h4000;
        @(posedge clk); #1;
        chk("R9", port_msg(2), {14'd0, 2'b10, 16'h2100, 32'h0000_0E02});
        @(negedge clk);
        cfg_wr = 1'b0;
        put(1, 2'b00, 16'h0000, 32'h0);
        @(posedge clk); #1;
        chk("R9", port_msg(2), {14'd0, 2'b10, 16'h2100, 32'h0000_0E01});
        @(negedge clk); idle_all();
        @(negedge clk);
        put(0, 2'b10, 16'h2100, 32'h0000_0E03);
        @(posedge clk); #1;
        chk("R9", port_msg(3), {14'd0, 2'b10, 16'h2100, 32'h0000_0E03});
        chk("R9", {56'd0, out_cls[5:4], 6'd0}, 64'd0);
        @(negedge clk); idle_all();
        cfg_put(2'd0, 2'd2, 16'h1800);

        // Vector walk (R1, R3, R4, R6, R7, R8)
        for (int v = 0; v < 12; v++) begin
            int src;
            int exp_p;
            src   = int'(VEC[v][54:53]);
            exp_p = int'(VEC[v][2:0]);
            @(negedge clk);
            idle_all();
            put(src, VEC[v][52:51], VEC[v][50:35], VEC[v][34:3]);
            #4;
            chk(VTAG[v], {63'd0, in_ready[src]}, 64'd1);
            @(posedge clk); #1;
            for (int o = 0; o < 4; o++) begin
                if (o == exp_p)
                    chk(VTAG[v], port_msg(o), {14'd0, VEC[v][52:3]});
                else
                    chk(VTAG[v], {62'd0, out_cls[2*o +: 2]}, 64'd0);
            end
        end
        @(negedge clk); idle_all();
        @(posedge clk); #1;
        chk("R2", {56'd0, out_cls}, 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule